// File: doc/BRIEF.md
# Sliding Aperture Window Translator

This block lets a host see a large local DRAM through a small, movable window. The host writes one 32-bit map word over a simple register-write port. That word sets three things: where the window starts in local memory, how large the window is, and whether translation is allowed at all. A single write can move the window and resize it in the same step.

Each host access carries an offset into the window. The block returns one of three results, one cycle later:
- a full local memory address, when the access is allowed;
- a disabled indication, when either enable bit is clear;
- a range error, when the translated address falls at or past the end of the local memory.

The memory size is a design parameter, given as log2 of the size in MiB. A requested window larger than the memory is shrunk to the memory size when the map word is written. The value that is held is readable on a status output.

Top module: `aperture_xlate`

## Requirements
- R1: While reset is asserted and after it is released, the held map word reads zero, the window is disabled, and no response output is asserted.
- R2: A map write keeps bits 29:20 (base in MiB), bits 7:4 (size code n, giving a 2^n MiB window) and bits 1:0 (bit 0 window enable, bit 1 register enable). Every other bit of the held word reads zero.
- R3: A written size code above MEM_LOG2_MB is stored as MEM_LOG2_MB, so the window never exceeds the memory.
- R4: A request made while bits 1:0 of the held word are not both one produces the disabled indication and no memory access.
- R5: An allowed request yields the address (base << 20) OR (offset AND (2^(20+n) - 1)).
- R6: A translated address at or above 2^(20+MEM_LOG2_MB) raises the range error and performs no memory access.
- R7: Each request produces exactly one of mem-valid, disabled or range-error on the cycle after it. No response appears without a request, and the address output is zero unless mem-valid is set.
- R8: A map write takes effect on the next cycle. A request in the same cycle as the write is translated with the old map, and the held word is unchanged in cycles with no write.
- R9: Host offset bits at or above the window size have no effect on the translated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Map word write strobe |
| cfg_wdata | input | 32 | Map word write data |
| map_q | output | 32 | Held map word, after the size clamp |
| req_valid | input | 1 | Host access request |
| req_off | input | HOST_W | Host offset into the window |
| rsp_mem_valid | output | 1 | Translated access is performed |
| rsp_addr | output | 30 | Local memory address, zero unless rsp_mem_valid |
| rsp_err_dis | output | 1 | Access refused: window or register access disabled |
| rsp_err_range | output | 1 | Access refused: address past memory size |

## Verification
The bench sweeps every size code 0 to 15 against a set of bases, including unaligned ones, and a set of offsets. The offsets include values with bits above the window, which separates a correct mask from a missing one, and codes above the memory code, which separate a clamped window from an unclamped one. The bases are chosen so some windows end inside the memory and some run past it, which tells a correct range check from a missing or off-by-one one. Each of the three non-enabled combinations of the two enable bits is tried separately. Back-to-back requests, and a request coinciding with a map write, show whether the response comes on the right cycle and uses the old mapping.

// File: rtl/aperture_pkg.sv
package aperture_pkg;
  localparam int MAP_W    = 32;
  localparam int MB_SHIFT = 20;
  localparam int BASE_W   = 10;
  localparam int CODE_W   = 4;
  localparam int LA_W     = MB_SHIFT + BASE_W;

  typedef struct packed {
    logic [BASE_W-1:0] base_mb;
    logic [CODE_W-1:0] size_code;
    logic              reg_en;
    logic              win_en;
  } map_t;
endpackage

// File: rtl/aperture_map_reg.sv
module aperture_map_reg
  import aperture_pkg::*;
#(
  parameter int MEM_LOG2_MB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [MAP_W-1:0] cfg_wdata,
  output map_t             map_o,
  output logic [MAP_W-1:0] map_word_o
);
  localparam logic [CODE_W-1:0] MEM_CODE = CODE_W'(MEM_LOG2_MB);

  map_t map_q, map_d;

  // next-state: unpack fields and clamp window to memory size
  always_comb begin
    map_d.base_mb   = cfg_wdata[29:20];
    map_d.size_code = cfg_wdata[7:4];
    map_d.reg_en    = cfg_wdata[1];
    map_d.win_en    = cfg_wdata[0];
    if (cfg_wdata[7:4] > MEM_CODE) map_d.size_code = MEM_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= '0;
    else if (cfg_we) map_q <= map_d;
  end

  assign map_o      = map_q;
  assign map_word_o = {2'b00, map_q.base_mb, 12'h000, map_q.size_code,
                       2'b00, map_q.reg_en, map_q.win_en};

  p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    map_q.size_code <= MEM_CODE);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(map_q));
endmodule

// File: rtl/aperture_addr_calc.sv
module aperture_addr_calc
  import aperture_pkg::*;
#(
  parameter int MEM_LOG2_MB = 4,
  parameter int HOST_W      = 30
) (
  input  map_t              map_i,
  input  logic [HOST_W-1:0] host_off,
  output logic [LA_W-1:0]   la_o,
  output logic              oob_o,
  output logic              en_o
);
  localparam int LIM_BIT = MB_SHIFT + MEM_LOG2_MB;

  logic [LA_W-1:0] off_ext;
  logic [LA_W:0]   span;
  logic [LA_W-1:0] mask;

  generate
    if (HOST_W >= LA_W) begin : g_trunc
      assign off_ext = host_off[LA_W-1:0];
    end else begin : g_zext
      assign off_ext = {{(LA_W-HOST_W){1'b0}}, host_off};
    end
  endgenerate

  always_comb begin
    span = (LA_W+1)'(1) << (MB_SHIFT + int'(map_i.size_code));
    mask = span[LA_W-1:0] - LA_W'(1);
    la_o = {map_i.base_mb, {MB_SHIFT{1'b0}}} | (off_ext & mask);
    en_o = map_i.win_en & map_i.reg_en;
  end

  generate
    if (LIM_BIT >= LA_W) begin : g_full_mem
      assign oob_o = 1'b0;
    end else begin : g_part_mem
      assign oob_o = |la_o[LA_W-1:LIM_BIT];
    end
  endgenerate
endmodule

// File: rtl/aperture_resp_stage.sv
module aperture_resp_stage
  import aperture_pkg::*;
#(
  parameter int MEM_LOG2_MB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            en_i,
  input  logic            oob_i,
  input  logic [LA_W-1:0] la_i,
  output logic            mem_valid_o,
  output logic [LA_W-1:0] addr_o,
  output logic            err_dis_o,
  output logic            err_range_o
);
  localparam logic [LA_W:0] LIMIT = (LA_W+1)'(1) << (MB_SHIFT + MEM_LOG2_MB);

  logic            mv_d, ed_d, er_d;
  logic [LA_W-1:0] addr_d;
  logic            mv_q, ed_q, er_q;
  logic [LA_W-1:0] addr_q;

  always_comb begin
    mv_d   = req_valid & en_i & ~oob_i;
    ed_d   = req_valid & ~en_i;
    er_d   = req_valid & en_i & oob_i;
    addr_d = mv_d ? la_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q   <= 1'b0;
      ed_q   <= 1'b0;
      er_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      mv_q   <= mv_d;
      ed_q   <= ed_d;
      er_q   <= er_d;
      addr_q <= addr_d;
    end
  end

  assign mem_valid_o = mv_q;
  assign addr_o      = addr_q;
  assign err_dis_o   = ed_q;
  assign err_range_o = er_q;

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mv_q, ed_q, er_q}));
  p_inmem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mv_q |-> ({1'b0, addr_q} < LIMIT));
  p_addr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mv_q |-> (addr_q == '0));
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import aperture_pkg::*;
#(
  parameter int MEM_LOG2_MB = 4,
  parameter int HOST_W      = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       map_q,
  input  logic              req_valid,
  input  logic [HOST_W-1:0] req_off,
  output logic              rsp_mem_valid,
  output logic [29:0]       rsp_addr,
  output logic              rsp_err_dis,
  output logic              rsp_err_range
);
  logic [1:0]      rst_sync;
  logic            rst_s;
  map_t            map_cur;
  logic [LA_W-1:0] la;
  logic            oob, en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  aperture_map_reg #(.MEM_LOG2_MB(MEM_LOG2_MB)) u_map (
    .clk        (clk),
    .rst_n      (rst_s),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .map_o      (map_cur),
    .map_word_o (map_q)
  );

  aperture_addr_calc #(.MEM_LOG2_MB(MEM_LOG2_MB), .HOST_W(HOST_W)) u_calc (
    .map_i    (map_cur),
    .host_off (req_off),
    .la_o     (la),
    .oob_o    (oob),
    .en_o     (en)
  );

  aperture_resp_stage #(.MEM_LOG2_MB(MEM_LOG2_MB)) u_resp (
    .clk         (clk),
    .rst_n       (rst_s),
    .req_valid   (req_valid),
    .en_i        (en),
    .oob_i       (oob),
    .la_i        (la),
    .mem_valid_o (rsp_mem_valid),
    .addr_o      (rsp_addr),
    .err_dis_o   (rsp_err_dis),
    .err_range_o (rsp_err_range)
  );

  p_resp_r7: assert property (@(posedge clk) disable iff (!rst_s)
    req_valid |=> (rsp_mem_valid | rsp_err_dis | rsp_err_range));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !req_valid |=> !(rsp_mem_valid | rsp_err_dis | rsp_err_range));
  p_dis_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && map_q[1:0] != 2'b11) |=> (rsp_err_dis && !rsp_mem_valid));
  p_reset_r1: assert property (@(posedge clk)
    !rst_s |-> (map_q == '0 && !rsp_mem_valid && !rsp_err_dis && !rsp_err_range));
endmodule

// File: tb/sim_aperture_xlate.sv
`timescale 1ns/1ps
module sim_aperture_xlate;
  localparam int MEM = 4;
  localparam int HW  = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   map_q;
  logic          req_valid = 1'b0;
  logic [HW-1:0] req_off = '0;
  logic          rsp_mem_valid;
  logic [29:0]   rsp_addr;
  logic          rsp_err_dis;
  logic          rsp_err_range;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  aperture_xlate #(.MEM_LOG2_MB(MEM), .HOST_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .map_q(map_q), .req_valid(req_valid), .req_off(req_off),
    .rsp_mem_valid(rsp_mem_valid), .rsp_addr(rsp_addr),
    .rsp_err_dis(rsp_err_dis), .rsp_err_range(rsp_err_range)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_map(input logic [31:0] w);
    logic [3:0] c;
    c = w[7:4];
    if (c > 4'(MEM)) c = 4'(MEM);
    return {2'b00, w[29:20], 12'h000, c, 2'b00, w[1:0]};
  endfunction

  // packs {mem_valid, err_dis, err_range, addr} expected for a held map word
  function automatic logic [63:0] exp_rsp(input logic [31:0] m, input logic [HW-1:0] off);
    logic [63:0] a, lim;
    a   = ({54'd0, m[29:20]} << 20) | ({34'd0, off} & ((64'd1 << (20 + m[7:4])) - 1));
    lim = 64'd1 << (20 + MEM);
    if (m[1:0] != 2'b11) return {31'd0, 3'b010, 30'd0};
    if (a >= lim)        return {31'd0, 3'b001, 30'd0};
    return {31'd0, 3'b100, a[29:0]};
  endfunction

  function automatic logic [63:0] act_rsp();
    return {31'd0, rsp_mem_valid, rsp_err_dis, rsp_err_range, rsp_addr};
  endfunction

  task automatic write_map(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic one_req(input logic [HW-1:0] off, input string tag);
    logic [31:0] m;
    m = map_q;
    @(negedge clk);
    req_valid = 1'b1; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, act_rsp(), exp_rsp(m, off));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [HW-1:0] offs [9];
    logic [9:0]    bases [8];
    logic [31:0]   ma, mb;
    offs  = '{30'h0, 30'h1, 30'hABCDE, 30'hFFFFF, 30'h100000, 30'h2345678,
              30'hFFFFFF, 30'h3FFFFFFF, 30'h1000000};
    bases = '{10'd0, 10'd1, 10'd2, 10'd5, 10'd8, 10'd15, 10'd16, 10'd1023};

    // R1: during and after reset
    repeat (3) @(negedge clk);
    check("R1 map in reset", {32'd0, map_q}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 map after reset", {32'd0, map_q}, 64'd0);
    check("R1 outputs idle", act_rsp(), 64'd0);
    one_req(30'h123, "R1 disabled after reset");

    // R2 and R3: field retention and size clamp
    write_map(32'hFFFF_FFFF);
    check("R2 R3 all ones", {32'd0, map_q}, {32'd0, exp_map(32'hFFFF_FFFF)});
    write_map(32'h1234_5672);
    check("R2 mixed word", {32'd0, map_q}, {32'd0, exp_map(32'h1234_5672)});
    for (int c = 0; c < 16; c++) begin
      write_map({2'b00, 10'd3, 12'h000, 4'(c), 4'h3});
      check("R3 code clamp", {32'd0, map_q}, {32'd0, exp_map({2'b00, 10'd3, 12'h000, 4'(c), 4'h3})});
    end

    // R4: each non-enabled combination
    for (int e = 0; e < 3; e++) begin
      write_map({2'b00, 10'd1, 12'h000, 4'd1, 2'b00, 2'(e)});
      one_req(30'h55, "R4 enable bits");
      one_req(30'h3FFFFFFF, "R4 enable bits far offset");
    end

    // R5 R6 R9: sweep codes, bases and offsets
    for (int c = 0; c < 16; c++) begin
      for (int b = 0; b < 8; b++) begin
        write_map({2'b00, bases[b], 12'h000, 4'(c), 4'h3});
        for (int o = 0; o < 9; o++) begin
          if (exp_rsp(map_q, offs[o])[31:30] == 2'b01) one_req(offs[o], "R6 range");
          else if (offs[o] >= (30'd1 << (20 + map_q[7:4]))) one_req(offs[o], "R9 high bits ignored");
          else one_req(offs[o], "R5 translate");
        end
      end
    end

    // R7: back-to-back requests, then idle
    write_map({2'b00, 10'd4, 12'h000, 4'd2, 4'h3});
    @(negedge clk);
    req_valid = 1'b1; req_off = 30'h11111;
    @(negedge clk);
    req_off = 30'h3FFFFF;
    check("R7 back-to-back first", act_rsp(), exp_rsp(map_q, 30'h11111));
    @(negedge clk);
    req_off = 30'h0;
    check("R7 back-to-back second", act_rsp(), exp_rsp(map_q, 30'h3FFFFF));
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 back-to-back third", act_rsp(), exp_rsp(map_q, 30'h0));
    @(negedge clk);
    check("R7 idle no response", act_rsp(), 64'd0);

    // R8: request in the same cycle as a map write uses the old map
    ma = {2'b00, 10'd2, 12'h000, 4'd1, 4'h3};
    mb = {2'b00, 10'd7, 12'h000, 4'd0, 4'h3};
    write_map(ma);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = mb; req_valid = 1'b1; req_off = 30'h1ABCDE;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R8 old map in flight", act_rsp(), exp_rsp(ma, 30'h1ABCDE));
    check("R8 map updated", {32'd0, map_q}, {32'd0, exp_map(mb)});
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 new map applied", act_rsp(), exp_rsp(mb, 30'h1ABCDE));
    repeat (3) @(negedge clk);
    check("R8 map held without write", {32'd0, map_q}, {32'd0, exp_map(mb)});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule